// File: doc/BRIEF.md
# Addressed Serial DAC Code Register

This block is the digital front end of a current-output converter. It listens on a three-wire serial bus (serial clock, serial data, active-low select) and collects 16-bit command words. When the select line goes back high, it examines the most recent 16 bits. A command carries a 4-bit address header and a 12-bit code. The block copies the code into its output register only when the header matches the block's own three strap pins, with a leading zero in front of them.

Several copies can sit on one bus. Copies with distinct straps are addressed one at a time. Copies that share a strap value all take the same word together. The bus signals are brought into a faster system clock through two-stage synchronisers, and their edges are detected in that clock domain. An active-low clear input empties the code register at any time. A standby input, held low, blocks updates while keeping the code that was last loaded. A one-cycle strobe marks every accepted update.

Top module: `addr_dac_slave`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into a 16-bit register, most significant bit first. The first four bits are the header. Its top bit is the fixed-zero bit and the next three bits are the address. The remaining twelve bits form the code, sent from bit 11 down to bit 0.
- R2: A word is evaluated only when `cs_n` rises. While a transfer is still in progress, `code` keeps its previous value, and `load_pulse` is never high while `cs_n` is low.
- R3: When a transfer has more than 16 clocks, only the last 16 bits shifted in are evaluated. Earlier bits are dropped, and their header plays no part.
- R4: A word is accepted only when its top header bit is 0 and the next three bits equal `strap[2]`, `strap[1]`, `strap[0]` in that order. On acceptance, `code` takes the low 12 bits of the word.
- R5: A word whose header does not match, including one with a 1 in the top header bit, leaves both `code` and `load_pulse` unchanged.
- R6: The shift register is emptied when `cs_n` falls. A transfer shorter than 16 clocks is therefore evaluated with zeros filling the leading positions.
- R7: Driving `clr_n` low forces `code` to zero at once, with no clock edge needed. While `clr_n` is low, no word can load. After `clr_n` is released, matching words load again.
- R8: While `stby_n` is low, no word can load. The current `code` is kept, both through standby and after standby ends.
- R9: `load_pulse` is high for exactly one system clock cycle for each accepted word. That cycle is the one in which `code` shows the new value. `code` never changes at any other time, except through clear or reset.
- R10: Two instances with the same strap value on a shared bus accept the same words, in the same cycle, with the same code.
- R11: The synchronous active-high `rst` sets `code` to zero and `load_pulse` to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial bus clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data, sampled on the rising edge of `sclk` |
| cs_n | input | 1 | Bus select, active low; its rising edge ends the word |
| clr_n | input | 1 | Asynchronous clear of the code register, active low |
| stby_n | input | 1 | Standby, active low; blocks loads |
| strap | input | 3 | Device address straps |
| code | output | 12 | Output code register |
| load_pulse | output | 1 | One-cycle strobe on each accepted update |

## Verification
Counting from the system clock edge that first samples `cs_n` high, the new code and the strobe appear after the third rising edge. Two edges come from the synchroniser and one from the code register. The bench raises `cs_n` on a falling edge. It then checks at the second falling edge that the strobe is low and the old code is still present, and at the third falling edge that the strobe and the new code have both appeared. A standby change needs two edges to pass the synchroniser, so the bench waits four cycles after each one. A clear needs no clock edge, so the bench checks it one time unit after `clr_n` falls.

// File: rtl/dac_slv_pkg.sv
package dac_slv_pkg;

  localparam int DEF_ADDR_W = 3;
  localparam int DEF_DATA_W = 12;
  localparam int DEF_SYNC   = 2;

  // header = one fixed-zero bit followed by the strap address
  function automatic int word_width(input int addr_w, input int data_w);
    return 1 + addr_w + data_w;
  endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              cs_n_s,
  output logic [WORD_W-1:0] word,
  output logic              word_done
);

  logic              sclk_q;
  logic              cs_q;
  logic [WORD_W-1:0] shreg;
  logic              sclk_rise;
  logic              cs_fall;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_fall   = ~cs_n_s & cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      if (cs_fall)
        shreg <= '0;
      else if (sclk_rise && !cs_n_s)
        shreg <= {shreg[WORD_W-2:0], sdi_s};
    end
  end

  assign word      = shreg;
  assign word_done = cs_n_s & ~cs_q;

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
  import dac_slv_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int WORD_W = word_width(ADDR_W, DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              stby_n_s,
  input  logic [ADDR_W-1:0] strap,
  input  logic [WORD_W-1:0] word,
  input  logic              word_done,
  output logic [DATA_W-1:0] code,
  output logic              load_pulse
);

  logic hdr_zero;
  logic addr_eq;
  logic take;

  assign hdr_zero = ~word[WORD_W-1];
  assign addr_eq  = (word[WORD_W-2 -: ADDR_W] == strap);
  assign take     = word_done & hdr_zero & addr_eq & stby_n_s;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      code       <= '0;
      load_pulse <= 1'b0;
    end else if (rst) begin
      code       <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= take;
      if (take) code <= word[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/addr_dac_slave.sv
module addr_dac_slave
  import dac_slv_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int SYNC   = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              clr_n,
  input  logic              stby_n,
  input  logic [ADDR_W-1:0] strap,
  output logic [DATA_W-1:0] code,
  output logic              load_pulse
);

  localparam int WORD_W = word_width(ADDR_W, DATA_W);

  logic [3:0]        raw_in;
  logic [3:0]        synced;
  logic [WORD_W-1:0] word;
  logic              word_done;

  assign raw_in = {stby_n, cs_n, sdi, sclk};

  dac_sync #(
    .W(4), .STAGES(SYNC), .RST_VAL(4'b1100)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );

  dac_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst),
    .sclk_s(synced[0]), .sdi_s(synced[1]), .cs_n_s(synced[2]),
    .word(word), .word_done(word_done)
  );

  dac_code_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_code (
    .clk(clk), .rst(rst), .clr_n(clr_n), .stby_n_s(synced[3]),
    .strap(strap), .word(word), .word_done(word_done),
    .code(code), .load_pulse(load_pulse)
  );

endmodule

// File: rtl/addr_dac_slave_chk.sv
module addr_dac_slave_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              clr_n,
  input logic              stby_n,
  input logic [DATA_W-1:0] code,
  input logic              load_pulse
);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);

  // R9
  code_change_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
    ((code != $past(code)) && $past(clr_n) && !$past(rst)) |-> load_pulse);

  // R7
  clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (code == '0));

  // R8
  standby_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(stby_n, 3) && !$past(stby_n, 2)) |-> !load_pulse);

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> (cs_n && $past(cs_n)));

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $past(rst) |-> ((code == '0) && !load_pulse));

endmodule

bind addr_dac_slave addr_dac_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .clr_n(clr_n), .stby_n(stby_n),
  .code(code), .load_pulse(load_pulse)
);

// File: tb/addr_dac_slave_bench.sv
module addr_dac_slave_bench;

  localparam logic [2:0] STRAP_A = 3'b101;
  localparam logic [2:0] STRAP_B = 3'b010;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic clr_n = 1'b1, stby_n = 1'b1;
  logic [11:0] code_a, code_t, code_b;
  logic lp_a, lp_t, lp_b;

  addr_dac_slave u_addr_dac_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .clr_n(clr_n),
    .stby_n(stby_n), .strap(STRAP_A), .code(code_a), .load_pulse(lp_a));
  addr_dac_slave u_addr_dac_slave_twin (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .clr_n(clr_n),
    .stby_n(stby_n), .strap(STRAP_A), .code(code_t), .load_pulse(lp_t));
  addr_dac_slave u_addr_dac_slave_other (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .clr_n(clr_n),
    .stby_n(stby_n), .strap(STRAP_B), .code(code_b), .load_pulse(lp_b));

  int total = 0, bad = 0;
  int pulses_a = 0, pulses_t = 0, pulses_b = 0, skew = 0;
  logic [11:0] exp_a = '0, exp_b = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (lp_a) pulses_a++;
    if (lp_t) pulses_t++;
    if (lp_b) pulses_b++;
    if (lp_a !== lp_t) skew++;
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] window(input logic [31:0] bits, input int n);
    if (n >= 16) return bits[15:0];
    return bits[15:0] & 16'((32'h1 << n) - 1);
  endfunction

  function automatic bit accept(input logic [15:0] w, input logic [2:0] s);
    return (w[15] == 1'b0) && (w[14:12] == s);
  endfunction

  task automatic xfer(input logic [31:0] bits, input int n, input string req);
    int pa0, pb0;
    logic [15:0] w;
    bit live, hit_a, hit_b;
    pa0 = pulses_a; pb0 = pulses_b;
    w = window(bits, n);
    live = clr_n && stby_n;
    hit_a = live && accept(w, STRAP_A);
    hit_b = live && accept(w, STRAP_B);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk("R2", "code held before select rises", code_a, exp_a);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "strobe not yet due", lp_a, 0);
    chk("R9", "code not yet due", code_a, exp_a);
    @(negedge clk);
    if (hit_a) exp_a = w[11:0];
    if (hit_b) exp_b = w[11:0];
    chk("R9", "strobe with new code", lp_a, hit_a);
    chk(req, "code A on time", code_a, exp_a);
    repeat (5) @(negedge clk);
    chk(req, "code A", code_a, exp_a);
    chk(req, "strobe count A", pulses_a - pa0, hit_a);
    chk(req, "code B", code_b, exp_b);
    chk(req, "strobe count B", pulses_b - pb0, hit_b);
    chk("R10", "twin code", code_t, code_a);
    chk("R10", "twin strobe count", pulses_t, pulses_a);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] bits;
    int n;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "code after reset", code_a, 0);
    chk("R11", "strobe after reset", lp_a, 0);

    // R1 R4: exact 16-bit words
    xfer(32'h0000_5ABC, 16, "R4");
    xfer(32'h0000_2123, 16, "R4");
    // R5: top header bit set, and a wrong address
    xfer(32'h0000_DFFF, 16, "R5");
    xfer(32'h0000_4777, 16, "R5");
    // R3: overlong transfers keep only the last 16 bits
    xfer(32'h000F_5321, 20, "R3");
    xfer(32'h0050_2456, 24, "R3");
    // R6: short transfers, zeros fill the leading bits
    xfer(32'h0000_0FFF, 12, "R6");
    xfer(32'h0000_5ABC, 15, "R6");

    // R8: standby blocks loads and keeps the code
    stby_n = 1'b0; repeat (4) @(negedge clk);
    xfer(32'h0000_5111, 16, "R8");
    stby_n = 1'b1; repeat (4) @(negedge clk);
    chk("R8", "code kept after standby", code_a, exp_a);
    xfer(32'h0000_5222, 16, "R8");

    // R7: asynchronous clear
    @(negedge clk); clr_n = 1'b0; #1;
    exp_a = '0; exp_b = '0;
    chk("R7", "code A cleared at once", code_a, 0);
    chk("R7", "code B cleared at once", code_b, 0);
    xfer(32'h0000_5333, 16, "R7");
    @(negedge clk); clr_n = 1'b1;
    xfer(32'h0000_5444, 16, "R7");

    // R11: synchronous reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    exp_a = '0; exp_b = '0;
    chk("R11", "code after mid-run reset", code_a, 0);
    chk("R11", "other code after mid-run reset", code_b, 0);

    // R1: random words of random length
    for (int k = 0; k < 40; k++) begin
      bits = $urandom;
      n = 10 + int'($urandom % 12);
      if ($urandom % 2 == 0) bits[15:12] = {1'b0, STRAP_A};
      else if ($urandom % 3 == 0) bits[15:12] = {1'b0, STRAP_B};
      xfer(bits, n, "R1");
    end

    chk("R10", "strobe skew cycles between twins", skew, 0);
    done = 1;
    finish_run();
  end

endmodule